// File: doc/BRIEF.md
# Speculative Invalid-Value Tracker

During a speculative pre-execution episode, while a long cache miss is outstanding, instructions run ahead only to produce prefetches and branch outcomes. Some of their operands are unknown. This block follows that unknown-ness. It holds one valid bit per architectural register and one poison bit per word of a small direct-mapped data-cache index space.

Each cycle at most one speculative instruction retires into the tracker. The instruction carries its class, its two source register numbers, its destination, its base register, a cache hit flag and the word index. The tracker reports at once whether the instruction's result is trustworthy. It updates its markers on the next clock edge.

A single-cycle clear closes the episode. The clear makes every register valid and removes every word poison mark. Data values, the cache array and the decision to enter or leave an episode belong to other blocks.

Top module: `ivt_tracker`

## Requirements
- R1: After reset every bit of `reg_valid_o` is 1 (1 = valid, 0 = invalid), and no cache word is poisoned, so a hitting load through a valid base reports `dst_ok_o` = 1.
- R2: An ALU instruction (class 0) whose source A or source B is invalid drives `dst_ok_o` low, and its destination bit reads 0 from the next cycle on.
- R3: An ALU instruction whose sources are both valid drives `dst_ok_o` high, and its destination bit reads 1 from the next cycle on, even if that bit was 0 before.
- R4: A load (class 1) drives `dst_ok_o` low, and marks its destination invalid, when any of three conditions holds: its base register is invalid, `hit_i` is 0, or the addressed word was poisoned earlier in the episode.
- R5: A load with a valid base that hits an unpoisoned word drives `dst_ok_o` high and marks its destination valid.
- R6: A store (class 2) poisons its word only when its base register is valid and `hit_i` is 1. A store with an invalid base, or one that misses, leaves the word readable as clean by later loads.
- R7: Register 0 always reads valid in `reg_valid_o[0]`, and it also counts as valid when used as a source. A write to register 0 has no effect.
- R8: A store or a branch (class 3) leaves `reg_valid_o` unchanged, and drives `dst_ok_o` low.
- R9: A `clear_i` pulse restores every register to valid and removes all word poison marks from the next cycle on. An instruction presented in the same cycle as the clear is dropped.
- R10: `dst_ok_o` follows the current marker state combinationally. `reg_valid_o` changes only on the clock edge that accepts an instruction or a clear, and it holds through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | End of episode: all markers back to valid |
| ins_valid_i | input | 1 | A speculative instruction retires this cycle |
| ins_cls_i | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| src_a_i | input | 5 | First source register (ALU) |
| src_b_i | input | 5 | Second source register (ALU) |
| dst_i | input | 5 | Destination register (ALU, load) |
| base_i | input | 5 | Address base register (load, store) |
| hit_i | input | 1 | Data-cache access hit |
| word_i | input | 6 | Cache word index of the access |
| dst_ok_o | output | 1 | Result of the presented instruction is valid |
| reg_valid_o | output | 32 | Per-register valid bits, 1 = valid |

## Verification
The assertions take three things for granted about the inputs:
- At most one instruction arrives per cycle.
- Register and word indices stay inside the parameterised ranges.
- A clear lasts a single cycle and may coincide with an instruction.

The stimulus keeps within these rules. It drives every input on the falling edge and holds each instruction for exactly one cycle. It uses indices below 32 and 64. Clears are pulsed as single cycles, and one of them deliberately overlaps an ALU instruction.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } ins_cls_e;
endpackage

// File: rtl/ivt_rules.sv
module ivt_rules
  import ivt_pkg::*;
(
  input  logic     go_i,
  input  ins_cls_e cls_i,
  input  logic     ok_a_i,
  input  logic     ok_b_i,
  input  logic     ok_base_i,
  input  logic     hit_i,
  input  logic     poisoned_i,
  output logic     dst_ok_o,
  output logic     wr_reg_o,
  output logic     psn_set_o
);
  always_comb begin
    dst_ok_o  = 1'b0;
    wr_reg_o  = 1'b0;
    psn_set_o = 1'b0;
    case (cls_i)
      CLS_ALU: begin
        dst_ok_o = ok_a_i & ok_b_i;
        wr_reg_o = go_i;
      end
      CLS_LOAD: begin
        dst_ok_o = ok_base_i & hit_i & ~poisoned_i;
        wr_reg_o = go_i;
      end
      CLS_STORE: psn_set_o = go_i & ok_base_i & hit_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/ivt_regvec.sv
module ivt_regvec #(
  parameter int NREG = 32,
  localparam int REGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            wr_en_i,
  input  logic [REGW-1:0] wr_idx_i,
  input  logic            wr_val_i,
  input  logic [REGW-1:0] rd_a_i,
  input  logic [REGW-1:0] rd_b_i,
  input  logic [REGW-1:0] rd_base_i,
  output logic            ok_a_o,
  output logic            ok_b_o,
  output logic            ok_base_o,
  output logic [NREG-1:0] vec_o
);
  logic [NREG-1:1] vld_q, vld_d;
  logic            upd_en;

  assign upd_en = clear_i | (wr_en_i & (wr_idx_i != '0));

  always_comb begin
    vld_d = vld_q;
    if (clear_i) vld_d = '1;
    else if (wr_en_i && wr_idx_i != '0) vld_d[wr_idx_i] = wr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '1;
    else if (upd_en) vld_q <= vld_d;
  end

  assign vec_o     = {vld_q, 1'b1};
  assign ok_a_o    = vec_o[rd_a_i];
  assign ok_b_o    = vec_o[rd_b_i];
  assign ok_base_o = vec_o[rd_base_i];
endmodule

// File: rtl/ivt_wordmask.sv
module ivt_wordmask #(
  parameter int NWORD = 64,
  localparam int WIDXW = $clog2(NWORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             set_en_i,
  input  logic [WIDXW-1:0] set_idx_i,
  input  logic [WIDXW-1:0] rd_idx_i,
  output logic             poisoned_o
);
  logic [NWORD-1:0] psn_q, psn_d;
  logic             upd_en;

  assign upd_en = clear_i | set_en_i;

  always_comb begin
    psn_d = psn_q;
    if (clear_i)       psn_d = '0;
    else if (set_en_i) psn_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psn_q <= '0;
    else if (upd_en) psn_q <= psn_d;
  end

  assign poisoned_o = psn_q[rd_idx_i];
endmodule

// File: rtl/ivt_tracker.sv
module ivt_tracker
  import ivt_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int NWORD = 64,
  localparam int REGW  = $clog2(NREG),
  localparam int WIDXW = $clog2(NWORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             ins_valid_i,
  input  logic [1:0]       ins_cls_i,
  input  logic [REGW-1:0]  src_a_i,
  input  logic [REGW-1:0]  src_b_i,
  input  logic [REGW-1:0]  dst_i,
  input  logic [REGW-1:0]  base_i,
  input  logic             hit_i,
  input  logic [WIDXW-1:0] word_i,
  output logic             dst_ok_o,
  output logic [NREG-1:0]  reg_valid_o
);
  ins_cls_e cls;
  logic     go, ok_a, ok_b, ok_base, poisoned, wr_reg, psn_set;

  assign cls = ins_cls_e'(ins_cls_i);
  assign go  = ins_valid_i & ~clear_i;

  ivt_regvec #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .wr_en_i(wr_reg), .wr_idx_i(dst_i), .wr_val_i(dst_ok_o),
    .rd_a_i(src_a_i), .rd_b_i(src_b_i), .rd_base_i(base_i),
    .ok_a_o(ok_a), .ok_b_o(ok_b), .ok_base_o(ok_base),
    .vec_o(reg_valid_o)
  );

  ivt_wordmask #(.NWORD(NWORD)) u_words (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .set_en_i(psn_set), .set_idx_i(word_i), .rd_idx_i(word_i),
    .poisoned_o(poisoned)
  );

  ivt_rules u_rules (
    .go_i(go), .cls_i(cls), .ok_a_i(ok_a), .ok_b_i(ok_b),
    .ok_base_i(ok_base), .hit_i(hit_i), .poisoned_i(poisoned),
    .dst_ok_o(dst_ok_o), .wr_reg_o(wr_reg), .psn_set_o(psn_set)
  );
endmodule

// File: rtl/ivt_tracker_chk.sv
module ivt_tracker_chk #(
  parameter int NREG = 32,
  localparam int REGW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear_i,
  input logic            ins_valid_i,
  input logic [1:0]      ins_cls_i,
  input logic [REGW-1:0] dst_i,
  input logic            dst_ok_o,
  input logic [NREG-1:0] reg_valid_o
);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (&reg_valid_o));

  // R2 and R3: the reported ALU verdict is what lands in the destination
  assert_alu_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !clear_i && ins_cls_i == 2'd0 && dst_i != '0)
    |=> reg_valid_o[$past(dst_i)] == $past(dst_ok_o));

  // R4 and R5: the same for loads
  assert_load_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !clear_i && ins_cls_i == 2'd1 && dst_i != '0)
    |=> reg_valid_o[$past(dst_i)] == $past(dst_ok_o));

  assert_nodst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !clear_i && ins_cls_i[1]) |=> $stable(reg_valid_o));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid_i && !clear_i) |=> $stable(reg_valid_o));
endmodule

bind ivt_tracker ivt_tracker_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .ins_valid_i(ins_valid_i),
  .ins_cls_i(ins_cls_i), .dst_i(dst_i), .dst_ok_o(dst_ok_o),
  .reg_valid_o(reg_valid_o)
);

// File: tb/ivt_tracker_test.sv
`timescale 1ns/1ps
module ivt_tracker_test;
  localparam int NREG = 32, NWORD = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clear_i, ins_valid_i, hit_i, dst_ok_o;
  logic [1:0] ins_cls_i;
  logic [4:0] src_a_i, src_b_i, dst_i, base_i;
  logic [5:0] word_i;
  logic [NREG-1:0] reg_valid_o;

  ivt_tracker uut (.*);

  typedef struct {
    string           req;
    bit              chk_ok;
    bit              exp_ok;
    logic [NREG-1:0] exp_vec;
  } item_t;

  item_t sbq[$];
  logic [NREG-1:0]  mvec;
  logic [NWORD-1:0] mpsn;
  int n_run = 0, n_fail = 0;
  bit drv_done = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [1:0] cls, input int a, input int b,
                       input int d, input int base, input bit hit, input int w);
    item_t it;
    bit ok;
    @(negedge clk);
    clear_i = 0; ins_valid_i = 1; ins_cls_i = cls;
    src_a_i = 5'(a); src_b_i = 5'(b); dst_i = 5'(d); base_i = 5'(base);
    hit_i = hit; word_i = 6'(w);
    case (cls)
      2'd0: ok = mvec[a] & mvec[b];
      2'd1: ok = mvec[base] & hit & ~mpsn[w];
      default: ok = 0;
    endcase
    it.req = req; it.chk_ok = 1; it.exp_ok = ok; it.exp_vec = mvec;
    sbq.push_back(it);
    if (cls < 2 && d != 0) mvec[d] = ok;
    if (cls == 2 && mvec[base] && hit) mpsn[w] = 1'b1;
  endtask

  task automatic idle(input string req);
    item_t it;
    @(negedge clk);
    ins_valid_i = 0; clear_i = 0;
    it.req = req; it.chk_ok = 0; it.exp_ok = 0; it.exp_vec = mvec;
    sbq.push_back(it);
  endtask

  // clear together with an ALU instruction that must be dropped
  task automatic clear_with_alu(input string req, input int a, input int d);
    item_t it;
    @(negedge clk);
    clear_i = 1; ins_valid_i = 1; ins_cls_i = 2'd0;
    src_a_i = 5'(a); src_b_i = 5'(a); dst_i = 5'(d);
    it.req = req; it.chk_ok = 0; it.exp_ok = 0; it.exp_vec = mvec;
    sbq.push_back(it);
    mvec = '1; mpsn = '0;
  endtask

  // monitor: compares one scoreboard item just after each falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check({it.req, " reg_valid_o"}, 64'(reg_valid_o), 64'(it.exp_vec));
        if (it.chk_ok) check({it.req, " dst_ok_o"}, 64'(dst_ok_o), 64'(it.exp_ok));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; clear_i = 0; ins_valid_i = 0; ins_cls_i = 0; hit_i = 0;
    src_a_i = 0; src_b_i = 0; dst_i = 0; base_i = 0; word_i = 0;
    mvec = '1; mpsn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 reset vector", 64'(reg_valid_o), 64'({NREG{1'b1}}));
    issue("R1", 2'd1, 0, 0, 2, 1, 1, 0);          // clean load after reset
    issue("R4 miss", 2'd1, 0, 0, 3, 1, 0, 2);
    issue("R5", 2'd1, 0, 0, 4, 1, 1, 2);
    issue("R2 srcB", 2'd0, 4, 3, 6, 0, 0, 0);
    issue("R2 srcA", 2'd0, 3, 4, 7, 0, 0, 0);
    issue("R3", 2'd0, 4, 1, 3, 0, 0, 0);           // r3 becomes valid again
    issue("R4 base", 2'd1, 0, 0, 8, 6, 1, 5);
    issue("R6 poison", 2'd2, 0, 0, 0, 1, 1, 10);
    issue("R4 poisoned", 2'd1, 0, 0, 9, 1, 1, 10);
    issue("R6 miss", 2'd2, 0, 0, 0, 1, 0, 11);
    issue("R6 miss no poison", 2'd1, 0, 0, 10, 1, 1, 11);
    issue("R6 bad base", 2'd2, 0, 0, 0, 6, 1, 12);
    issue("R6 bad base no poison", 2'd1, 0, 0, 11, 1, 1, 12);
    issue("R7 write r0", 2'd1, 0, 0, 0, 1, 0, 13);
    issue("R7 r0 source", 2'd0, 0, 0, 12, 0, 0, 0);
    issue("R8 branch", 2'd3, 6, 7, 14, 6, 0, 0);
    issue("R8 store", 2'd2, 0, 0, 15, 8, 0, 20);
    idle("R10 idle");
    issue("R10", 2'd0, 6, 0, 16, 0, 0, 0);
    clear_with_alu("R9 clear", 6, 13);
    issue("R9 after clear", 2'd1, 0, 0, 9, 1, 1, 10);
    issue("R9 regs", 2'd0, 6, 8, 17, 0, 0, 0);
    idle("R9 end");
    @(negedge clk);
    ins_valid_i = 0;
    drv_done = 1;
    wait (sbq.size() == 0);
    @(negedge clk); #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule